// File: doc/BRIEF.md
# Banked Register Access Decoder

This block decodes the operand fields of the processor's "move to/from banked register" operations. Each request carries a one-bit selector that picks between general registers and saved status registers, a 5-bit system-register field, the index of the general register used as source or destination, and a snapshot of the execution context. The context holds the user-mode flag, the non-secure flag, the current exception level, and three feature flags: v8 architecture, virtualization, and security. From these the block works out which processor mode and which register the operation targets. When the operation is not permitted in that context, it reports an undefined-instruction trap and names the exception level that takes the trap.

The block gives a verdict based only on encoding and static context. The checks that depend on the processor mode at run time are left to the execution stage that consumes the result. Requests enter over a valid/ready port and results leave over a second valid/ready port, with a single register stage between them. A request transfers on a clock edge where `in_valid` and `in_ready` are both high. A result transfers on a clock edge where `out_valid` and `out_ready` are both high. A result that is held back stays unchanged, and while it waits the input accepts nothing new. Results keep the order in which requests were accepted.

Top module: `banked_access_decoder`

## Requirements
- R1: `in_ready` is high when the output register is empty or `out_ready` is high. A request accepted at an edge appears on `out_valid` at the next edge, and a result held by low `out_ready` keeps all fields unchanged. Results leave in acceptance order.
- R2: When neither the v8 flag nor the virtualization flag is set, every request gives undef.
- R3: A request issued in user mode, or whose general register index is all ones (15), gives undef.
- R4: With selector 1, the field values 0x0E, 0x10, 0x12, 0x14, 0x16, 0x1C and 0x1E pick the saved status register of FIQ, IRQ, SVC, ABT, UND, MON and HYP respectively, with register number 16. Every other field value gives undef.
- R5: With selector 0, field values 0x00..0x06 give USR R8..R14 (register number = field + 8), and 0x08..0x0E give FIQ R8..R14 (register number = field).
- R6: With selector 0, the pairs 0x10/0x11, 0x12/0x13, 0x14/0x15, 0x16/0x17 and 0x1C/0x1D pick IRQ, SVC, ABT, UND and MON. The odd value gives register 13 and the even value gives register 14.
- R7: With selector 0, 0x1F gives HYP register 13 and 0x1E gives the HYP exception link register as register number 17. The values 0x07, 0x0F and 0x18..0x1B give undef.
- R8: A MON target gives undef when the security flag is clear or the state is non-secure. Otherwise, at exception level 1 it gives undef with trap level 3.
- R9: A HYP target gives undef unless the virtualization flag is set and the current exception level is 3.
- R10: Mode codes are USR 0x10, FIQ 0x11, IRQ 0x12, SVC 0x13, MON 0x16, ABT 0x17, HYP 0x1A, UND 0x1B. On undef, mode and register number are 0 and the trap level is the current level, or 1 when the current level is 0 (except the R8 redirect). Without undef the trap level is 0.
- R11: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_spsr_sel | input | 1 | 1 selects saved status registers, 0 selects general registers |
| in_sysm | input | 5 | System-register field |
| in_gpr | input | GPR_W | Source/destination general register index |
| ctx_user | input | 1 | Request issued in user mode |
| ctx_nonsecure | input | 1 | Non-secure state |
| ctx_el | input | 2 | Current exception level |
| feat_v8 | input | 1 | v8 architecture present |
| feat_virt | input | 1 | Virtualization (EL2) present |
| feat_sec | input | 1 | Security (EL3) present |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_undef | output | 1 | Operation traps as undefined |
| out_mode | output | 5 | Target mode code |
| out_regno | output | 5 | Target register number |
| out_trap_el | output | 2 | Exception level taking the trap |

## Verification
The hardest case to reach is the trap redirect to level 3. It needs every earlier gate to pass: a feature flag present, not user mode, a legal register index, a MON encoding, the security flag set and the secure state, all while the current level is exactly 1. Randomly chosen context almost never lines up this way. Directed requests therefore build that exact context for both MON encodings and for the MON status register. Neighbouring requests each change one condition, so that the redirect shows up only in the intended case. A second pass repeats the field sweep with stalls on the output, so that results held across several cycles are also compared.

// File: rtl/bkd_pkg.sv
package bkd_pkg;
  localparam int SYSM_W = 5;
  localparam int MODE_W = 5;
  localparam int REGN_W = 5;
  localparam int EL_W   = 2;

  localparam logic [MODE_W-1:0] MODE_NONE = 5'h00;
  localparam logic [MODE_W-1:0] MODE_USR  = 5'h10;
  localparam logic [MODE_W-1:0] MODE_FIQ  = 5'h11;
  localparam logic [MODE_W-1:0] MODE_IRQ  = 5'h12;
  localparam logic [MODE_W-1:0] MODE_SVC  = 5'h13;
  localparam logic [MODE_W-1:0] MODE_MON  = 5'h16;
  localparam logic [MODE_W-1:0] MODE_ABT  = 5'h17;
  localparam logic [MODE_W-1:0] MODE_HYP  = 5'h1A;
  localparam logic [MODE_W-1:0] MODE_UND  = 5'h1B;

  localparam logic [REGN_W-1:0] REGN_LOW = 5'd8;
  localparam logic [REGN_W-1:0] REGN_SP  = 5'd13;
  localparam logic [REGN_W-1:0] REGN_LR  = 5'd14;
  localparam logic [REGN_W-1:0] REGN_PSR = 5'd16;
  localparam logic [REGN_W-1:0] REGN_ELR = 5'd17;

  typedef struct packed {
    logic              undef;
    logic [MODE_W-1:0] mode;
    logic [REGN_W-1:0] regno;
    logic [EL_W-1:0]   trap_el;
  } bkd_res_t;

  // Upper half of the field is organised as pairs; bits [3:1] name the mode.
  function automatic logic [MODE_W-1:0] pair_mode(input logic [2:0] grp);
    case (grp)
      3'd0:    pair_mode = MODE_IRQ;
      3'd1:    pair_mode = MODE_SVC;
      3'd2:    pair_mode = MODE_ABT;
      3'd3:    pair_mode = MODE_UND;
      3'd6:    pair_mode = MODE_MON;
      3'd7:    pair_mode = MODE_HYP;
      default: pair_mode = MODE_NONE;
    endcase
  endfunction
endpackage

// File: rtl/bkd_map.sv
module bkd_map
  import bkd_pkg::*;
(
  input  logic              psr_sel,
  input  logic [SYSM_W-1:0] sysm,
  output logic              hit,
  output logic [MODE_W-1:0] mode,
  output logic [REGN_W-1:0] regno
);
  logic [MODE_W-1:0] grp_mode;

  assign grp_mode = pair_mode(sysm[3:1]);

  always_comb begin
    hit   = 1'b0;
    mode  = MODE_NONE;
    regno = '0;
    if (psr_sel) begin
      // saved status registers: FIQ sits alone, others reuse the pair table
      regno = REGN_PSR;
      if (sysm == 5'h0E) begin
        hit  = 1'b1;
        mode = MODE_FIQ;
      end else if (sysm[4] && !sysm[0] && grp_mode != MODE_NONE) begin
        hit  = 1'b1;
        mode = grp_mode;
      end
    end else if (!sysm[4]) begin
      // two banks of seven: USR then FIQ, R8..R14
      if (sysm[2:0] != 3'b111) begin
        hit   = 1'b1;
        mode  = sysm[3] ? MODE_FIQ : MODE_USR;
        regno = REGN_LOW + {2'b00, sysm[2:0]};
      end
    end else if (grp_mode != MODE_NONE) begin
      hit  = 1'b1;
      mode = grp_mode;
      if (sysm[0])                regno = REGN_SP;
      else if (grp_mode == MODE_HYP) regno = REGN_ELR;
      else                        regno = REGN_LR;
    end
  end
endmodule

// File: rtl/bkd_gate.sv
module bkd_gate
  import bkd_pkg::*;
#(
  parameter int GPR_W = 4
)(
  input  logic              feat_v8,
  input  logic              feat_virt,
  input  logic              feat_sec,
  input  logic              ctx_user,
  input  logic              ctx_nonsecure,
  input  logic [EL_W-1:0]   ctx_el,
  input  logic [GPR_W-1:0]  gpr,
  input  logic              hit,
  input  logic [MODE_W-1:0] mode,
  output logic              undef,
  output logic [EL_W-1:0]   trap_el
);
  localparam logic [GPR_W-1:0] PC_IDX = '1;
  localparam logic [EL_W-1:0]  EL_ONE = EL_W'(1);
  localparam logic [EL_W-1:0]  EL_TOP = EL_W'(3);

  logic present, ctx_ok, base_ok;
  logic is_mon, is_hyp, mon_deny, mon_up, hyp_deny;
  logic [EL_W-1:0] dflt_el;

  assign present  = feat_v8 | feat_virt;
  assign ctx_ok   = !ctx_user && (gpr != PC_IDX);
  assign base_ok  = present && ctx_ok && hit;

  assign is_mon   = (mode == MODE_MON);
  assign is_hyp   = (mode == MODE_HYP);
  assign mon_deny = is_mon && (!feat_sec || ctx_nonsecure);
  assign mon_up   = is_mon && !mon_deny && (ctx_el == EL_ONE);
  assign hyp_deny = is_hyp && (!feat_virt || ctx_el != EL_TOP);

  assign undef    = !base_ok || mon_deny || mon_up || hyp_deny;
  assign dflt_el  = (ctx_el == '0) ? EL_ONE : ctx_el;
  assign trap_el  = (base_ok && mon_up) ? EL_TOP : dflt_el;
endmodule

// File: rtl/bkd_stage.sv
module bkd_stage #(
  parameter int W = 8
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         vld_q;
  logic [W-1:0] dat_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) dat_q <= in_data;
    end
  end
endmodule

// File: rtl/banked_access_decoder.sv
module banked_access_decoder
  import bkd_pkg::*;
#(
  parameter int GPR_W = 4
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_spsr_sel,
  input  logic [4:0]       in_sysm,
  input  logic [GPR_W-1:0] in_gpr,
  input  logic             ctx_user,
  input  logic             ctx_nonsecure,
  input  logic [1:0]       ctx_el,
  input  logic             feat_v8,
  input  logic             feat_virt,
  input  logic             feat_sec,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_undef,
  output logic [4:0]       out_mode,
  output logic [4:0]       out_regno,
  output logic [1:0]       out_trap_el
);
  localparam int RES_W = $bits(bkd_res_t);

  logic              map_hit;
  logic [MODE_W-1:0] map_mode;
  logic [REGN_W-1:0] map_regno;
  logic              gate_undef;
  logic [EL_W-1:0]   gate_el;
  bkd_res_t          res_d, res_q;
  logic [RES_W-1:0]  res_q_bits;

  bkd_map u_map (
    .psr_sel (in_spsr_sel),
    .sysm    (in_sysm),
    .hit     (map_hit),
    .mode    (map_mode),
    .regno   (map_regno)
  );

  bkd_gate #(.GPR_W(GPR_W)) u_gate (
    .feat_v8       (feat_v8),
    .feat_virt     (feat_virt),
    .feat_sec      (feat_sec),
    .ctx_user      (ctx_user),
    .ctx_nonsecure (ctx_nonsecure),
    .ctx_el        (ctx_el),
    .gpr           (in_gpr),
    .hit           (map_hit),
    .mode          (map_mode),
    .undef         (gate_undef),
    .trap_el       (gate_el)
  );

  always_comb begin
    res_d.undef   = gate_undef;
    res_d.mode    = gate_undef ? MODE_NONE : map_mode;
    res_d.regno   = gate_undef ? '0 : map_regno;
    res_d.trap_el = gate_undef ? gate_el : '0;
  end

  bkd_stage #(.W(RES_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (res_d),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (res_q_bits)
  );

  assign res_q       = bkd_res_t'(res_q_bits);
  assign out_undef   = res_q.undef;
  assign out_mode    = res_q.mode;
  assign out_regno   = res_q.regno;
  assign out_trap_el = res_q.trap_el;
endmodule

// File: rtl/bkd_checker.sv
module bkd_checker #(
  parameter int GPR_W = 4
)(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_spsr_sel,
  input logic [4:0]       in_sysm,
  input logic [GPR_W-1:0] in_gpr,
  input logic             ctx_user,
  input logic             feat_v8,
  input logic             feat_virt,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_undef,
  input logic [4:0]       out_mode,
  input logic [4:0]       out_regno,
  input logic [1:0]       out_trap_el
);
  logic take;
  assign take = in_valid && in_ready;

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_undef) && $stable(out_mode)
      && $stable(out_regno) && $stable(out_trap_el));

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  assert_nofeat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take && !feat_v8 && !feat_virt |=> out_undef);

  assert_ctx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take && (ctx_user || in_gpr == '1) |=> out_undef);

  assert_regset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_undef |-> out_regno >= 5'd8 && out_regno <= 5'd17 && out_regno != 5'd15);

  assert_hypvirt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take && !feat_virt && !in_spsr_sel && in_sysm[4:1] == 4'hF |=> out_undef);

  assert_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_undef |-> out_mode == 5'd0 && out_regno == 5'd0 && out_trap_el != 2'd0);

  assert_notrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_undef |-> out_trap_el == 2'd0 && out_mode != 5'd0);
endmodule

bind banked_access_decoder bkd_checker #(.GPR_W(GPR_W)) u_bkd_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_spsr_sel (in_spsr_sel),
  .in_sysm     (in_sysm),
  .in_gpr      (in_gpr),
  .ctx_user    (ctx_user),
  .feat_v8     (feat_v8),
  .feat_virt   (feat_virt),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_undef   (out_undef),
  .out_mode    (out_mode),
  .out_regno   (out_regno),
  .out_trap_el (out_trap_el)
);

// File: tb/test_banked_access_decoder.sv
module test_banked_access_decoder;
  typedef struct packed {
    logic       undef;
    logic [4:0] mode;
    logic [4:0] regno;
    logic [1:0] trap;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       in_spsr_sel = 1'b0;
  logic [4:0] in_sysm = '0;
  logic [3:0] in_gpr = '0;
  logic       ctx_user = 1'b0, ctx_nonsecure = 1'b0;
  logic [1:0] ctx_el = '0;
  logic       feat_v8 = 1'b0, feat_virt = 1'b0, feat_sec = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic       out_undef;
  logic [4:0] out_mode, out_regno;
  logic [1:0] out_trap_el;

  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;
  bit   bp = 1'b0;
  int   cyc = 0;
  exp_t exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  banked_access_decoder i_banked_access_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_spsr_sel(in_spsr_sel), .in_sysm(in_sysm), .in_gpr(in_gpr),
    .ctx_user(ctx_user), .ctx_nonsecure(ctx_nonsecure), .ctx_el(ctx_el),
    .feat_v8(feat_v8), .feat_virt(feat_virt), .feat_sec(feat_sec),
    .out_valid(out_valid), .out_ready(out_ready), .out_undef(out_undef),
    .out_mode(out_mode), .out_regno(out_regno), .out_trap_el(out_trap_el)
  );

  task automatic chk(input bit ok, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s", what);
    end
  endtask

  // Expected result derived from the requirement list
  function automatic exp_t model(input logic sel, input logic [4:0] sx, input logic [3:0] g,
                                 input logic usr, input logic ns, input logic [1:0] el,
                                 input logic v8, input logic vz, input logic sc,
                                 output string tg);
    exp_t e;
    logic ok;
    logic [4:0] m, n;
    logic [1:0] dflt, trap;
    logic [4:0] pair;
    dflt = (el == 2'd0) ? 2'd1 : el;
    trap = dflt;
    ok = 1'b1; m = 5'h00; n = 5'd0;
    pair = 5'h00;
    case (sx & 5'h1E)
      5'h10: pair = 5'h12;
      5'h12: pair = 5'h13;
      5'h14: pair = 5'h17;
      5'h16: pair = 5'h1B;
      5'h1C: pair = 5'h16;
      5'h1E: pair = 5'h1A;
      default: pair = 5'h00;
    endcase
    if (sel) begin
      tg = "R4";
      n = 5'd16;
      if (sx == 5'h0E) m = 5'h11;
      else if (!sx[0] && pair != 5'h00) m = pair;
      else ok = 1'b0;
    end else if (sx <= 5'h06) begin
      tg = "R5"; m = 5'h10; n = sx + 5'd8;
    end else if (sx >= 5'h08 && sx <= 5'h0E) begin
      tg = "R5"; m = 5'h11; n = sx;
    end else if (sx == 5'h1E) begin
      tg = "R7"; m = 5'h1A; n = 5'd17;
    end else if (sx == 5'h1F) begin
      tg = "R7"; m = 5'h1A; n = 5'd13;
    end else if (pair != 5'h00) begin
      tg = "R6"; m = pair; n = sx[0] ? 5'd13 : 5'd14;
    end else begin
      tg = "R7"; ok = 1'b0;
    end
    if (!(v8 || vz)) begin
      tg = "R2"; ok = 1'b0;
    end else if (usr || g == 4'd15) begin
      tg = "R3"; ok = 1'b0;
    end else if (!ok) begin
      ok = 1'b0;
    end else if (m == 5'h16 && (!sc || ns)) begin
      tg = "R8"; ok = 1'b0;
    end else if (m == 5'h16 && el == 2'd1) begin
      tg = "R8"; ok = 1'b0; trap = 2'd3;
    end else if (m == 5'h1A && (!vz || el != 2'd3)) begin
      tg = "R9"; ok = 1'b0;
    end
    if (ok) begin
      e.undef = 1'b0; e.mode = m; e.regno = n; e.trap = 2'd0;
    end else begin
      e.undef = 1'b1; e.mode = 5'h00; e.regno = 5'd0; e.trap = trap;
      tg = {tg, "/R10"};
    end
    return e;
  endfunction

  // driver: pushes expected items as requests are accepted
  task automatic send(input logic sel, input logic [4:0] sx, input logic [3:0] g,
                      input logic usr, input logic ns, input logic [1:0] el,
                      input logic v8, input logic vz, input logic sc);
    string tg;
    exp_t  e;
    e = model(sel, sx, g, usr, ns, el, v8, vz, sc, tg);
    @(negedge clk);
    in_spsr_sel = sel; in_sysm = sx; in_gpr = g;
    ctx_user = usr; ctx_nonsecure = ns; ctx_el = el;
    feat_v8 = v8; feat_virt = vz; feat_sec = sc;
    in_valid = 1'b1;
    while (1) begin
      #8;
      if (in_ready) break;
      @(negedge clk);
    end
    exp_q.push_back(e);
    tag_q.push_back(tg);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // back-pressure generator
  always @(negedge clk) begin
    cyc++;
    out_ready = bp ? ((cyc % 3) == 2) : 1'b1;
  end

  // monitor: compares results as they leave, and checks held results (R1)
  initial begin
    exp_t  held;
    bit    held_v;
    exp_t  e;
    string tg;
    held_v = 1'b0;
    held = '0;
    forever begin
      @(negedge clk);
      #8;
      if (rst_n && out_valid) begin
        if (held_v) begin
          total++;
          if ({out_undef, out_mode, out_regno, out_trap_el} != held) begin
            bad++;
            $display("FAIL R1 hold: got %h expected %h",
                     {out_undef, out_mode, out_regno, out_trap_el}, held);
          end
        end
        if (out_ready) begin
          held_v = 1'b0;
          total++;
          if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL R1 unexpected result: got %h expected none",
                     {out_undef, out_mode, out_regno, out_trap_el});
          end else begin
            e  = exp_q.pop_front();
            tg = tag_q.pop_front();
            if (out_undef !== e.undef || out_mode !== e.mode ||
                out_regno !== e.regno || out_trap_el !== e.trap) begin
              bad++;
              $display("FAIL %s: got undef=%0d mode=%h regno=%0d trap=%0d expected undef=%0d mode=%h regno=%0d trap=%0d",
                       tg, out_undef, out_mode, out_regno, out_trap_el,
                       e.undef, e.mode, e.regno, e.trap);
            end
          end
        end else begin
          held_v = 1'b1;
          held = {out_undef, out_mode, out_regno, out_trap_el};
        end
      end else begin
        held_v = 1'b0;
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R11 reset state
    chk(out_valid == 1'b0, $sformatf("R11 out_valid: got %0d expected 0", out_valid));
    chk(in_ready == 1'b1, $sformatf("R11 in_ready: got %0d expected 1", in_ready));

    // full sweep in a permissive context: R4 R5 R6 R7
    for (int s = 0; s < 64; s++)
      send(s[5], s[4:0], 4'd3, 1'b0, 1'b0, 2'd3, 1'b1, 1'b1, 1'b1);

    // R2 no feature
    send(1'b0, 5'h02, 4'd1, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1);
    send(1'b0, 5'h02, 4'd1, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1);
    // R3 user mode, index 15
    send(1'b0, 5'h12, 4'd2, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0);
    send(1'b0, 5'h12, 4'd15, 1'b0, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0);
    // R8 monitor target
    send(1'b0, 5'h1C, 4'd0, 1'b0, 1'b1, 2'd3, 1'b1, 1'b1, 1'b1);
    send(1'b0, 5'h1D, 4'd0, 1'b0, 1'b0, 2'd3, 1'b1, 1'b1, 1'b0);
    send(1'b0, 5'h1C, 4'd0, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1);
    send(1'b0, 5'h1D, 4'd0, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1);
    send(1'b1, 5'h1C, 4'd0, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1);
    send(1'b0, 5'h1C, 4'd0, 1'b0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b1);
    send(1'b0, 5'h1C, 4'd15, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1);
    send(1'b0, 5'h1D, 4'd0, 1'b0, 1'b0, 2'd2, 1'b1, 1'b0, 1'b1);
    // R9 hyp target
    send(1'b0, 5'h1E, 4'd4, 1'b0, 1'b0, 2'd2, 1'b1, 1'b1, 1'b1);
    send(1'b0, 5'h1F, 4'd4, 1'b0, 1'b0, 2'd1, 1'b1, 1'b1, 1'b1);
    send(1'b1, 5'h1E, 4'd4, 1'b0, 1'b0, 2'd3, 1'b1, 1'b0, 1'b1);
    send(1'b0, 5'h1F, 4'd4, 1'b0, 1'b0, 2'd3, 1'b0, 1'b1, 1'b0);
    // R10 default trap level from level 0
    send(1'b0, 5'h07, 4'd4, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0);

    // R1 second sweep under back-pressure with varied context
    bp = 1'b1;
    for (int s = 0; s < 64; s++)
      send(s[5], s[4:0], 4'(s % 16), 1'b0, s[1], 2'(s % 4), 1'b1, s[0], s[2]);
    idle();

    n = 0;
    while (exp_q.size() != 0 && n < 400) begin
      @(negedge clk);
      n++;
    end
    bp = 1'b0;
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, $sformatf("R1 drain: got %0d pending expected 0", exp_q.size()));

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule